// File: doc/BRIEF.md
# Label-Switched Path Record Table with Sequential Key Search

This block holds the path records of a signalling coprocessor and answers questions about them. A host builds a record one 32-bit word at a time in a staging buffer. Each record has six words, and the host places each word in a slot it chooses. When all six slots hold data, a commit strobe copies the staged record as a whole into the lowest unused table entry and marks that entry valid. Entries are only ever added, so the lowest unused entry is always the one after the last filled entry.

To look up a path, the host first loads five key registers. It then starts a search. The search spends a fixed number of cycles setting up. It then visits the filled entries one by one, from index 0 upward, at a fixed cost per entry. Key k is compared with word k of each record, for k from 0 to 4. The sixth word is payload and is never compared. The search ends at the first matching entry. It then raises a done pulse, together with a hit flag and the index of that entry. If no entry matches, it raises the done pulse with the hit flag low.

Neighbouring logic reads any stored word directly by entry and word number. This lets it fetch, for example, the port number held in the payload word.

Top module: `lsp_table`

## Requirements
- R1: After reset, `busy`, `cmt_done` and `srch_done` are low, and every entry reads back with `rd_valid` low.
- R2: A word write (`wr_en` with `wr_sel` from 0 to 5) is accepted only when the block is idle. `busy` is high for exactly two cycles after the accepting edge. The word then lands in staging slot `wr_sel`.
- R3: A commit is accepted when idle and takes six cycles. `cmt_done` pulses for one cycle on the sixth edge after acceptance. If the commit succeeds, `cmt_err` is low, the staged record is stored at index N (the number of entries filled before), that entry becomes valid, and the staging slots count as empty again.
- R4: A commit issued while any of the six slots has not been written since reset or since the last successful commit ends with `cmt_err` high. The table is not changed.
- R5: A commit issued while all 32 entries are filled ends with `cmt_err` high. The stored contents are left unchanged.
- R6: `key_wr` with `key_sel` k (0 to 4) sets key k. During a search, key k is compared with record word k. Word 5 takes no part in the comparison.
- R7: A search first takes three set-up cycles, then three cycles per entry examined. If the first matching entry is index k, `srch_done` pulses with `srch_hit` high and `srch_idx` equal to k, 6+3k edges after acceptance. An earlier matching entry always takes precedence over a later one.
- R8: If no entry matches and N entries are filled, `srch_done` pulses with `srch_hit` low 3+3N edges after acceptance.
- R9: Entries that have never been committed are never reported as matches, even if their stored words equal the keys.
- R10: While `busy` is high, every command (write, commit, key load, search start) is ignored and produces no result.
- R11: `rd_data` shows word `rd_sel` of entry `rd_idx` combinationally, and `rd_valid` shows whether that entry has been committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write a word into staging |
| wr_sel | input | 3 | Staging slot 0..5 |
| wr_data | input | 32 | Word to stage |
| commit | input | 1 | Save the staged record into the next free entry |
| key_wr | input | 1 | Load one key register |
| key_sel | input | 3 | Key number 0..4 |
| key_data | input | 32 | Key value |
| srch_start | input | 1 | Start a search |
| rd_idx | input | 5 | Entry to read |
| rd_sel | input | 3 | Word of the entry to read |
| busy | output | 1 | An operation is in progress |
| cmt_done | output | 1 | One-cycle commit completion pulse |
| cmt_err | output | 1 | Commit was rejected (valid with cmt_done) |
| srch_done | output | 1 | One-cycle search completion pulse |
| srch_hit | output | 1 | A match was found (valid with srch_done) |
| srch_idx | output | 5 | Index of the first match |
| rd_data | output | 32 | Selected stored word |
| rd_valid | output | 1 | Selected entry is committed |

## Verification
Every result arrives a fixed number of edges after its command is accepted:
- a word write clears `busy` two edges after acceptance;
- a commit reports six edges after acceptance;
- a search reports 6+3k edges after acceptance on a hit at index k, and 3+3N edges after acceptance on a miss.

When the bench issues a command, it stores the expected outcome together with the exact cycle number at which it is due. The monitor compares each done pulse against the oldest stored item, both its value and the cycle on which it appears. A pulse that arrives when nothing is expected counts as a failure. This is how a command issued while `busy` is high and wrongly acted upon is caught.

// File: rtl/lsp_table_pkg.sv
package lsp_table_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WRITE,
        ST_COMMIT,
        ST_INIT,
        ST_SCAN
    } ctrl_st_e;
endpackage

// File: rtl/lsp_stage.sv
module lsp_stage #(
    parameter int WORD_W    = 32,
    parameter int REC_WORDS = 6,
    parameter int SEL_W     = 3
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                ld,
    input  logic [SEL_W-1:0]                    ld_sel,
    input  logic [WORD_W-1:0]                   ld_data,
    input  logic                                clr,
    output logic [REC_WORDS-1:0][WORD_W-1:0]    rec,
    output logic                                full
);
    typedef struct packed {
        logic [REC_WORDS-1:0][WORD_W-1:0] words;
        logic [REC_WORDS-1:0]             seen;
    } stage_t;

    stage_t stg_d, stg_q;

    always_comb begin
        stg_d = stg_q;
        if (clr) begin
            stg_d.seen = '0;
        end else if (ld) begin
            stg_d.words[ld_sel] = ld_data;
            stg_d.seen[ld_sel]  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) stg_q <= '0;
        else        stg_q <= stg_d;
    end

    assign rec  = stg_q.words;
    assign full = &stg_q.seen;
endmodule

// File: rtl/lsp_store.sv
module lsp_store #(
    parameter int WORD_W    = 32,
    parameter int REC_WORDS = 6,
    parameter int DEPTH     = 32,
    parameter int NKEYS     = 5,
    parameter int IDX_W     = 5,
    parameter int SEL_W     = 3
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                we,
    input  logic [IDX_W-1:0]                    widx,
    input  logic [REC_WORDS-1:0][WORD_W-1:0]    wrec,
    input  logic [IDX_W-1:0]                    cmp_idx,
    input  logic [NKEYS-1:0][WORD_W-1:0]        keys,
    output logic                                cmp_hit,
    input  logic [IDX_W-1:0]                    rd_idx,
    input  logic [SEL_W-1:0]                    rd_sel,
    output logic [WORD_W-1:0]                   rd_data,
    output logic                                rd_valid
);
    typedef struct packed {
        logic [DEPTH-1:0][REC_WORDS-1:0][WORD_W-1:0] mem;
        logic [DEPTH-1:0]                            vld;
    } store_t;

    store_t st_d, st_q;
    logic [NKEYS-1:0] key_eq;

    always_comb begin
        st_d = st_q;
        if (we) begin
            st_d.mem[widx] = wrec;
            st_d.vld[widx] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // one comparator per key, applied to the entry under examination
    for (genvar k = 0; k < NKEYS; k++) begin : g_key
        assign key_eq[k] = (st_q.mem[cmp_idx][k] == keys[k]);
    end

    assign cmp_hit  = st_q.vld[cmp_idx] && (&key_eq);
    assign rd_valid = st_q.vld[rd_idx];
    assign rd_data  = ({1'b0, rd_sel} < (SEL_W+1)'(REC_WORDS)) ? st_q.mem[rd_idx][rd_sel] : '0;

    // R3
    free_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> !st_q.vld[widx]);
endmodule

// File: rtl/lsp_ctrl.sv
module lsp_ctrl
    import lsp_table_pkg::*;
#(
    parameter int WORD_W     = 32,
    parameter int REC_WORDS  = 6,
    parameter int DEPTH      = 32,
    parameter int NKEYS      = 5,
    parameter int IDX_W      = 5,
    parameter int SEL_W      = 3,
    parameter int KSEL_W     = 3,
    parameter int WR_CYC     = 2,
    parameter int COMMIT_CYC = 6,
    parameter int INIT_CYC   = 3,
    parameter int ENTRY_CYC  = 3
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [SEL_W-1:0]                wr_sel,
    input  logic [WORD_W-1:0]               wr_data,
    input  logic                            commit,
    input  logic                            key_wr,
    input  logic [KSEL_W-1:0]               key_sel,
    input  logic [WORD_W-1:0]               key_data,
    input  logic                            srch_start,
    input  logic                            stage_full,
    input  logic                            cmp_hit,
    output logic                            stage_ld,
    output logic [SEL_W-1:0]                stage_sel,
    output logic [WORD_W-1:0]               stage_data,
    output logic                            stage_clr,
    output logic                            mem_we,
    output logic [IDX_W-1:0]                mem_widx,
    output logic [IDX_W-1:0]                cmp_idx,
    output logic [NKEYS-1:0][WORD_W-1:0]    keys,
    output logic                            busy,
    output logic                            cmt_done,
    output logic                            cmt_err,
    output logic                            srch_done,
    output logic                            srch_hit,
    output logic [IDX_W-1:0]                srch_idx
);
    localparam int MAXC1  = (WR_CYC > COMMIT_CYC) ? WR_CYC : COMMIT_CYC;
    localparam int MAXC2  = (INIT_CYC > ENTRY_CYC) ? INIT_CYC : ENTRY_CYC;
    localparam int MAXC   = (MAXC1 > MAXC2) ? MAXC1 : MAXC2;
    localparam int CYC_W  = $clog2(MAXC + 1);
    localparam int FILL_W = IDX_W + 1;

    typedef struct packed {
        ctrl_st_e                       st;
        logic [CYC_W-1:0]               cnt;
        logic [SEL_W-1:0]               psel;
        logic [WORD_W-1:0]              pdata;
        logic                           ok;
        logic [FILL_W-1:0]              fill;
        logic [IDX_W-1:0]               idx;
        logic [NKEYS-1:0][WORD_W-1:0]   keys;
        logic                           cdone;
        logic                           cerr;
        logic                           sdone;
        logic                           shit;
        logic [IDX_W-1:0]               sidx;
    } ctl_t;

    ctl_t c_d, c_q;
    logic last_cnt;

    assign last_cnt = (c_q.cnt == '0);

    always_comb begin
        c_d       = c_q;
        c_d.cdone = 1'b0;
        c_d.sdone = 1'b0;
        unique case (c_q.st)
            ST_IDLE: begin
                if (commit) begin
                    c_d.st  = ST_COMMIT;
                    c_d.cnt = CYC_W'(COMMIT_CYC - 1);
                    c_d.ok  = stage_full && (c_q.fill < FILL_W'(DEPTH));
                end else if (wr_en && ({1'b0, wr_sel} < (SEL_W+1)'(REC_WORDS))) begin
                    c_d.st    = ST_WRITE;
                    c_d.cnt   = CYC_W'(WR_CYC - 1);
                    c_d.psel  = wr_sel;
                    c_d.pdata = wr_data;
                end else if (srch_start) begin
                    c_d.st   = ST_INIT;
                    c_d.cnt  = CYC_W'(INIT_CYC - 1);
                    c_d.shit = 1'b0;
                    c_d.idx  = '0;
                end else if (key_wr && ({1'b0, key_sel} < (KSEL_W+1)'(NKEYS))) begin
                    c_d.keys[key_sel] = key_data;
                end
            end
            ST_WRITE: begin
                if (last_cnt) c_d.st  = ST_IDLE;
                else          c_d.cnt = c_q.cnt - 1'b1;
            end
            ST_COMMIT: begin
                if (last_cnt) begin
                    c_d.st    = ST_IDLE;
                    c_d.cdone = 1'b1;
                    c_d.cerr  = !c_q.ok;
                    if (c_q.ok) c_d.fill = c_q.fill + 1'b1;
                end else begin
                    c_d.cnt = c_q.cnt - 1'b1;
                end
            end
            ST_INIT: begin
                if (last_cnt) begin
                    if (c_q.fill == '0) begin
                        c_d.st    = ST_IDLE;
                        c_d.sdone = 1'b1;
                    end else begin
                        c_d.st  = ST_SCAN;
                        c_d.cnt = CYC_W'(ENTRY_CYC - 1);
                    end
                end else begin
                    c_d.cnt = c_q.cnt - 1'b1;
                end
            end
            ST_SCAN: begin
                if (last_cnt) begin
                    if (cmp_hit) begin
                        c_d.st    = ST_IDLE;
                        c_d.sdone = 1'b1;
                        c_d.shit  = 1'b1;
                        c_d.sidx  = c_q.idx;
                    end else if (FILL_W'(c_q.idx) + 1'b1 == c_q.fill) begin
                        c_d.st    = ST_IDLE;
                        c_d.sdone = 1'b1;
                    end else begin
                        c_d.idx = c_q.idx + 1'b1;
                        c_d.cnt = CYC_W'(ENTRY_CYC - 1);
                    end
                end else begin
                    c_d.cnt = c_q.cnt - 1'b1;
                end
            end
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign stage_ld   = (c_q.st == ST_WRITE) && last_cnt;
    assign stage_sel  = c_q.psel;
    assign stage_data = c_q.pdata;
    assign mem_we     = (c_q.st == ST_COMMIT) && last_cnt && c_q.ok;
    assign stage_clr  = mem_we;
    assign mem_widx   = c_q.fill[IDX_W-1:0];
    assign cmp_idx    = c_q.idx;
    assign keys       = c_q.keys;
    assign busy       = (c_q.st != ST_IDLE);
    assign cmt_done   = c_q.cdone;
    assign cmt_err    = c_q.cerr;
    assign srch_done  = c_q.sdone;
    assign srch_hit   = c_q.shit;
    assign srch_idx   = c_q.sidx;

    // R5
    full_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.cdone && c_q.cerr) |-> $stable(c_q.fill));

    // R7
    hit_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.sdone && c_q.shit) |-> (FILL_W'(c_q.sidx) < c_q.fill));

    // R10
    no_preempt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st == ST_WRITE) |=> (c_q.st == ST_WRITE || c_q.st == ST_IDLE));

    // R3
    cmt_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.cdone |=> !c_q.cdone);
endmodule

// File: rtl/lsp_table.sv
module lsp_table #(
    parameter int WORD_W     = 32,
    parameter int REC_WORDS  = 6,
    parameter int DEPTH      = 32,
    parameter int NKEYS      = 5,
    parameter int WR_CYC     = 2,
    parameter int COMMIT_CYC = 6,
    parameter int INIT_CYC   = 3,
    parameter int ENTRY_CYC  = 3,
    localparam int IDX_W     = $clog2(DEPTH),
    localparam int SEL_W     = $clog2(REC_WORDS),
    localparam int KSEL_W    = $clog2(NKEYS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [SEL_W-1:0]   wr_sel,
    input  logic [WORD_W-1:0]  wr_data,
    input  logic               commit,
    input  logic               key_wr,
    input  logic [KSEL_W-1:0]  key_sel,
    input  logic [WORD_W-1:0]  key_data,
    input  logic               srch_start,
    input  logic [IDX_W-1:0]   rd_idx,
    input  logic [SEL_W-1:0]   rd_sel,
    output logic               busy,
    output logic               cmt_done,
    output logic               cmt_err,
    output logic               srch_done,
    output logic               srch_hit,
    output logic [IDX_W-1:0]   srch_idx,
    output logic [WORD_W-1:0]  rd_data,
    output logic               rd_valid
);
    logic                               stage_ld, stage_clr, stage_full;
    logic [SEL_W-1:0]                   stage_sel;
    logic [WORD_W-1:0]                  stage_data;
    logic [REC_WORDS-1:0][WORD_W-1:0]   stage_rec;
    logic                               mem_we, cmp_hit;
    logic [IDX_W-1:0]                   mem_widx, cmp_idx;
    logic [NKEYS-1:0][WORD_W-1:0]       keys;

    lsp_ctrl #(
        .WORD_W(WORD_W), .REC_WORDS(REC_WORDS), .DEPTH(DEPTH), .NKEYS(NKEYS),
        .IDX_W(IDX_W), .SEL_W(SEL_W), .KSEL_W(KSEL_W), .WR_CYC(WR_CYC),
        .COMMIT_CYC(COMMIT_CYC), .INIT_CYC(INIT_CYC), .ENTRY_CYC(ENTRY_CYC)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .commit(commit),
        .key_wr(key_wr), .key_sel(key_sel), .key_data(key_data),
        .srch_start(srch_start), .stage_full(stage_full), .cmp_hit(cmp_hit),
        .stage_ld(stage_ld), .stage_sel(stage_sel), .stage_data(stage_data),
        .stage_clr(stage_clr), .mem_we(mem_we), .mem_widx(mem_widx),
        .cmp_idx(cmp_idx), .keys(keys), .busy(busy),
        .cmt_done(cmt_done), .cmt_err(cmt_err), .srch_done(srch_done),
        .srch_hit(srch_hit), .srch_idx(srch_idx)
    );

    lsp_stage #(.WORD_W(WORD_W), .REC_WORDS(REC_WORDS), .SEL_W(SEL_W)) u_stage (
        .clk(clk), .rst_n(rst_n), .ld(stage_ld), .ld_sel(stage_sel),
        .ld_data(stage_data), .clr(stage_clr), .rec(stage_rec), .full(stage_full)
    );

    lsp_store #(
        .WORD_W(WORD_W), .REC_WORDS(REC_WORDS), .DEPTH(DEPTH), .NKEYS(NKEYS),
        .IDX_W(IDX_W), .SEL_W(SEL_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n), .we(mem_we), .widx(mem_widx), .wrec(stage_rec),
        .cmp_idx(cmp_idx), .keys(keys), .cmp_hit(cmp_hit),
        .rd_idx(rd_idx), .rd_sel(rd_sel), .rd_data(rd_data), .rd_valid(rd_valid)
    );
endmodule

// File: tb/lsp_table_bench.sv
`timescale 1ns/1ps
module lsp_table_bench;
    localparam int DEPTH = 32;
    localparam int NREC  = 6;
    localparam int NK    = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, commit = 1'b0, key_wr = 1'b0, srch_start = 1'b0;
    logic [2:0]  wr_sel = '0, key_sel = '0, rd_sel = '0;
    logic [31:0] wr_data = '0, key_data = '0;
    logic [4:0]  rd_idx = '0;
    logic        busy, cmt_done, cmt_err, srch_done, srch_hit, rd_valid;
    logic [4:0]  srch_idx;
    logic [31:0] rd_data;

    lsp_table u_lsp_table (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .commit(commit), .key_wr(key_wr), .key_sel(key_sel), .key_data(key_data),
        .srch_start(srch_start), .rd_idx(rd_idx), .rd_sel(rd_sel), .busy(busy),
        .cmt_done(cmt_done), .cmt_err(cmt_err), .srch_done(srch_done),
        .srch_hit(srch_hit), .srch_idx(srch_idx), .rd_data(rd_data), .rd_valid(rd_valid)
    );

    always #4 clk = ~clk;

    int n_run = 0, n_fail = 0;
    longint cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        bit     is_srch;
        bit     flag;
        int     idx;
        longint due;
        string  req;
    } exp_t;
    exp_t exp_q[$];

    logic [31:0] ref_mem [DEPTH][NREC];
    logic [31:0] stg [NREC];
    bit          seen [NREC];
    logic [31:0] kref [NK];
    int          fill = 0;
    bit          done_flag = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
        end
    endtask

    // monitor: pops expected results as the design reports them
    always @(negedge clk) begin
        if (rst_n && (cmt_done || srch_done)) begin
            if (exp_q.size() == 0) begin
                chk(0, "R10 unexpected result", 1, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(srch_done == e.is_srch && cmt_done == !e.is_srch, {e.req, " kind"}, srch_done, e.is_srch);
                chk(cyc == e.due, {e.req, " latency"}, cyc, e.due);
                if (e.is_srch) begin
                    chk(srch_hit == e.flag, {e.req, " hit"}, srch_hit, e.flag);
                    if (e.flag) chk(srch_idx == e.idx, {e.req, " index"}, srch_idx, e.idx);
                end else begin
                    chk(cmt_err == e.flag, {e.req, " error"}, cmt_err, e.flag);
                end
            end
        end
    end

    function automatic logic [31:0] recw(input int i, input int w);
        int src;
        src = (i == 3 && w < NK) ? 1 : i;   // entry 3 duplicates the keys of entry 1
        return 32'h5100_0000 + (src << 8) + w + ((i == 3 && w == 5) ? 32'h80 : 0);
    endfunction

    task automatic write_word(input int sel, input logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; wr_sel = 3'(sel); wr_data = d;
        @(negedge clk); wr_en = 1'b0;
        chk(busy == 1'b1, "R2 busy first cycle", busy, 1);
        @(negedge clk);
        chk(busy == 1'b1, "R2 busy second cycle", busy, 1);
        @(negedge clk);
        chk(busy == 1'b0, "R2 busy released", busy, 0);
        stg[sel] = d; seen[sel] = 1'b1;
    endtask

    task automatic load_key(input int k, input logic [31:0] d);
        @(negedge clk); key_wr = 1'b1; key_sel = 3'(k); key_data = d;
        @(negedge clk); key_wr = 1'b0;
        kref[k] = d;
    endtask

    task automatic do_commit(input bit noise);
        exp_t e;
        bit all = 1'b1;
        @(negedge clk); commit = 1'b1;
        for (int w = 0; w < NREC; w++) all &= seen[w];
        e.is_srch = 0; e.due = cyc + 1 + 6; e.idx = fill;
        e.flag = !all || fill == DEPTH;
        e.req  = !e.flag ? "R3" : (fill == DEPTH ? "R5" : "R4");
        exp_q.push_back(e);
        if (!e.flag) begin
            for (int w = 0; w < NREC; w++) begin ref_mem[fill][w] = stg[w]; seen[w] = 1'b0; end
            fill++;
        end
        @(negedge clk); commit = 1'b0;
        if (noise) begin   // R10: all of these land while busy
            wr_en = 1'b1; wr_sel = 3'd0; wr_data = 32'hDEAD_0000;
            srch_start = 1'b1; key_wr = 1'b1; key_sel = 3'd0; key_data = 32'hBAD0_BAD0;
            @(negedge clk);
            wr_en = 1'b0; srch_start = 1'b0; key_wr = 1'b0;
        end
        while (cyc <= e.due) @(negedge clk);
    endtask

    task automatic do_search(input string req, input bit noise);
        exp_t e;
        int hit_at = -1;
        @(negedge clk); srch_start = 1'b1;
        for (int i = 0; i < fill && hit_at < 0; i++) begin
            bit m = 1'b1;
            for (int k = 0; k < NK; k++) if (ref_mem[i][k] != kref[k]) m = 1'b0;
            if (m) hit_at = i;
        end
        e.is_srch = 1; e.req = req;
        e.flag = (hit_at >= 0); e.idx = hit_at;
        e.due  = cyc + 1 + 3 + (e.flag ? 3 * (hit_at + 1) : 3 * fill);
        exp_q.push_back(e);
        @(negedge clk); srch_start = 1'b0;
        if (noise) begin   // R10: a commit while scanning must be ignored
            commit = 1'b1;
            @(negedge clk); commit = 1'b0;
        end
        while (cyc <= e.due) @(negedge clk);
    endtask

    task automatic keys_of(input int i);
        for (int k = 0; k < NK; k++) load_key(k, ref_mem[i][k]);
    endtask

    task automatic stage_rec(input int i);
        for (int w = 0; w < NREC; w++) write_word(w, recw(i, w));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done_flag) begin
            n_run++; n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < NK; k++) kref[k] = '0;
        for (int w = 0; w < NREC; w++) begin stg[w] = '0; seen[w] = 1'b0; end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(busy == 1'b0, "R1 busy", busy, 0);
        chk(cmt_done == 1'b0 && srch_done == 1'b0, "R1 done", cmt_done | srch_done, 0);
        rd_idx = 5'd0; #1;
        chk(rd_valid == 1'b0, "R1 entry0 invalid", rd_valid, 0);
        rd_idx = 5'd31; #1;
        chk(rd_valid == 1'b0, "R1 entry31 invalid", rd_valid, 0);

        // R9/R8: all-zero keys against all-zero empty storage must miss after 3 cycles
        do_search("R9 empty table", 1'b0);
        // R4: nothing staged
        do_commit(1'b0);
        // R4: five of six slots staged
        for (int w = 0; w < NREC - 1; w++) write_word(w, recw(0, w));
        do_commit(1'b0);
        write_word(5, recw(0, 5));
        do_commit(1'b0);  // R3 stored at 0
        // R11 read back
        rd_idx = 5'd0;
        for (int w = 0; w < NREC; w++) begin
            rd_sel = 3'(w); #1;
            chk(rd_data == recw(0, w), "R11 read word", rd_data, recw(0, w));
        end
        chk(rd_valid == 1'b1, "R11 valid after commit", rd_valid, 1);

        for (int i = 1; i < 5; i++) begin stage_rec(i); do_commit(i == 4); end
        // after the noisy commit, staging is empty: a commit must be rejected (R10, R4)
        do_commit(1'b0);

        keys_of(2);
        do_search("R7 hit index 2", 1'b0);
        keys_of(1);
        do_search("R7 first of duplicates", 1'b1);
        // R6: word 5 is not compared, so entry 3 (payload differs) still shadows nothing beyond 1
        load_key(4, 32'h0000_0001);
        do_search("R6 changed key misses", 1'b0);
        keys_of(0);
        do_search("R6 entry 0 payload ignored", 1'b0);

        for (int i = 5; i < DEPTH; i++) begin stage_rec(i); do_commit(1'b0); end
        // R5: table full
        for (int w = 0; w < NREC; w++) write_word(w, 32'h7700_0000 + w);
        do_commit(1'b0);
        rd_idx = 5'd31; rd_sel = 3'd5; #1;
        chk(rd_data == recw(31, 5), "R5 last entry unchanged", rd_data, recw(31, 5));
        for (int k = 0; k < NK; k++) load_key(k, 32'h7700_0000 + k);
        do_search("R5 rejected record absent", 1'b0);
        keys_of(31);
        do_search("R7 worst case last entry", 1'b0);

        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R10 outstanding results", exp_q.size(), 0);
        done_flag = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule